// File: doc/BRIEF.md
# Thermometer-Pattern Address Match with Hold

This block decides whether a 16-bit address bus carries one particular pattern. The pattern is chosen by a 4-bit select value n. The n lowest bus positions must be low, and every position above them must be high. A select value is normally tied to a fixed board or slot number, so one small code picks one of sixteen address windows without storing a full 16-bit compare word.

The result is active low. It passes through a holding stage controlled by a tracking enable. While the enable is high, the output follows the comparison. While it is low, the output keeps its last value whatever the bus and select do.

The block is built for a synchronous fabric. The hold stage is a clocked register rather than a level-sensitive latch. It has a synchronous active-high reset that forces the output to the no-match level.

Top module: `thermo_match_hold`

## Requirements
- R1: Bit i of `addr` (i = 0..15) stands for bus position i+1, and `sel` is an unsigned value from 0 to 15.
- R2: For `sel` = n, the expected pattern has bits 0..n-1 low and bits n..15 high. Bit i is expected high exactly when i >= n.
- R3: At the ends of the range: with `sel` = 0 only the all-ones bus matches, and with `sel` = 15 only the bus with bit 15 alone high matches.
- R4: While `track` is high, `match_n` becomes 0 after the next rising `clk` edge if `addr` equals the expected pattern, and 1 otherwise. A single differing bit gives 1.
- R5: While `track` is low, `match_n` keeps its value across clock edges, and changes on `sel` or `addr` have no effect on it.
- R6: `rst` is synchronous and active high. After an edge where it is high, `match_n` is 1, and this takes priority over `track`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; forces the no-match level |
| sel | input | 4 | Programmed count n that picks the thermometer pattern |
| addr | input | 16 | Address bus under test; bit 0 is position 1 |
| track | input | 1 | High: output follows the comparison; low: output holds |
| match_n | output | 1 | Registered result; 0 when the bus matched while tracking |

## Verification
Reset and a tracking update can land on the same clock edge. The bench provokes this by raising `rst` while `track` is high and `addr` carries a matching pattern. Reset is judged correct only if `match_n` reads 1 after that edge rather than the 0 the comparison would give. A second overlap is a hold that begins on the same cycle the bus changes. The bench drops `track` together with a change of `addr` and `sel`, and expects the value captured before the drop to stay.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int DEFAULT_SEL_W = 4;

  // Width of the compared bus for a given select width.
  function automatic int bus_width(input int sel_w);
    return 1 << sel_w;
  endfunction
endpackage

// File: rtl/thermo_decode.sv
module thermo_decode #(
  parameter int SEL_W = 4,
  parameter int BUS_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  output logic [BUS_W-1:0] want
);
  // Bit g of the expected word is high when its index reaches the count.
  for (genvar g = 0; g < BUS_W; g++) begin : g_bit
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign want[g] = (sel <= IDX);
  end
endmodule

// File: rtl/thermo_compare.sv
module thermo_compare #(
  parameter int BUS_W = 16
) (
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] want,
  output logic             hit
);
  logic [BUS_W-1:0] same;

  for (genvar g = 0; g < BUS_W; g++) begin : g_eq
    assign same[g] = ~(addr[g] ^ want[g]);
  end

  assign hit = &same;
endmodule

// File: rtl/hold_reg.sv
module hold_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b1;
    else if (en) q <= d;
  end

  // R5: with the enable low the stored value does not move
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  // R6: reset leaves the no-match level
  a_r6_reset_level: assert property (@(posedge clk)
    rst |=> q);
endmodule

// File: rtl/thermo_match_hold.sv
module thermo_match_hold import thermo_pkg::*; #(
  parameter int SEL_W = DEFAULT_SEL_W,
  localparam int BUS_W = bus_width(SEL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [BUS_W-1:0] addr,
  input  logic             track,
  output logic             match_n
);
  logic [BUS_W-1:0] want;
  logic [BUS_W-1:0] low_part;
  logic             hit;

  thermo_decode #(.SEL_W(SEL_W), .BUS_W(BUS_W)) u_decode (
    .sel  (sel),
    .want (want)
  );

  thermo_compare #(.BUS_W(BUS_W)) u_compare (
    .addr (addr),
    .want (want),
    .hit  (hit)
  );

  hold_reg u_hold (
    .clk (clk),
    .rst (rst),
    .en  (track),
    .d   (~hit),
    .q   (match_n)
  );

  assign low_part = ~want;

  // R2: exactly sel positions are expected low
  a_r2_low_count: assert property (@(posedge clk) disable iff (rst)
    $countones(low_part) == int'(sel));

  // R2: the expected-low positions form one run starting at bit 0
  a_r2_thermo_shape: assert property (@(posedge clk) disable iff (rst)
    (low_part & (low_part + {{(BUS_W-1){1'b0}}, 1'b1})) == '0);

  // R4: while tracking, the output takes the inverted compare result
  a_r4_follow: assert property (@(posedge clk) disable iff (rst)
    track |=> (match_n == !$past(hit)));
endmodule

// File: tb/test_thermo_match_hold.sv
module test_thermo_match_hold;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sel = '0;
  logic [15:0] addr = '0;
  logic        track = 1'b0;
  logic        match_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermo_match_hold i_thermo_match_hold (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .addr    (addr),
    .track   (track),
    .match_n (match_n)
  );

  // {sel, addr, expected match_n}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {4'd0,  16'hFFFF, 1'b0},
    {4'd0,  16'hFFFE, 1'b1},
    {4'd7,  16'hFF80, 1'b0},
    {4'd7,  16'hFF00, 1'b1},
    {4'd7,  16'hFFC0, 1'b1},
    {4'd15, 16'h8000, 1'b0},
    {4'd15, 16'h0000, 1'b1},
    {4'd15, 16'hC000, 1'b1},
    {4'd1,  16'hFFFE, 1'b0},
    {4'd8,  16'h00FF, 1'b1}
  };

  function automatic logic [15:0] pattern(input logic [3:0] n);
    logic [15:0] p;
    for (int j = 0; j < 16; j++) p[j] = (j >= int'(n));
    return p;
  endfunction

  task automatic check(input string req, input logic exp, input logic act);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: match_n=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] s, input logic [15:0] a, input logic t);
    @(negedge clk);
    sel = s; addr = a; track = t;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check("R6", 1'b1, match_n);
    rst = 1'b0;

    // R1 R2 R3 R4: table of vectors
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][20:17], VEC[v][16:1], 1'b1);
      check("R4", VEC[v][0], match_n);
    end

    // R2 R4: every count, exact pattern and each single-bit flip
    for (int n = 0; n < 16; n++) begin
      step(4'(n), pattern(4'(n)), 1'b1);
      check("R2", 1'b0, match_n);
      for (int b = 0; b < 16; b++) begin
        step(4'(n), pattern(4'(n)) ^ (16'h1 << b), 1'b1);
        check("R4", 1'b1, match_n);
      end
    end

    // R4: random buses
    for (int k = 0; k < 200; k++) begin
      logic [3:0]  s;
      logic [15:0] a;
      s = 4'($urandom_range(0, 15));
      a = (k % 2 == 0) ? 16'($urandom) : pattern(s);
      step(s, a, 1'b1);
      check("R4", (a == pattern(s)) ? 1'b0 : 1'b1, match_n);
    end

    // R5: hold a match, change inputs in the same cycle track drops
    step(4'd3, pattern(4'd3), 1'b1);
    check("R5", 1'b0, match_n);
    step(4'd9, 16'h1234, 1'b0);
    check("R5", 1'b0, match_n);
    for (int k = 0; k < 5; k++) begin
      step(4'(k), 16'($urandom), 1'b0);
      check("R5", 1'b0, match_n);
    end
    // R5: hold a mismatch while a matching bus appears
    step(4'd5, 16'h0000, 1'b1);
    check("R4", 1'b1, match_n);
    step(4'd5, pattern(4'd5), 1'b0);
    check("R5", 1'b1, match_n);
    step(4'd5, pattern(4'd5), 1'b1);
    check("R4", 1'b0, match_n);

    // R6: reset and a matching update on the same edge
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6", 1'b1, match_n);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R4", 1'b0, match_n);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule